// File: doc/BRIEF.md
# Serial Slave Front End with Transfer Pause

This block is the serial-bus front end of a memory slave attached over a four-wire serial link. It brings the chip select, serial clock, data-in and pause (hold) pins into one fast system clock domain and detects their edges there. From those edges it assembles incoming bytes, shifts outgoing bytes onto the data-out pin, and drives an enable for that pin's tri-state buffer. A command decoder downstream consumes the byte stream and supplies the next outgoing byte.

Three safety rules shape its control logic. While the supply-good input is low, the block stays cleared and ignores every pin. After power-up, a low chip select does not select the block until that pin has been seen high and then falling. A pause input can freeze a transfer without losing the bit position, and a deselect during a pause abandons the transfer. A standby flag tells the power logic when the bus is idle and no write cycle is running.

Top module: `spi_hold_frontend`

## Requirements
- R1: After reset, and after supply-good returns, the block is not selected even if chip select is low. `selected_o` rises only after chip select has been sampled high and then low.
- R2: While `pwr_ok_i` is low, `selected_o`, `held_o`, `miso_oe_o`, `standby_o` and `rx_valid_o` stay low, and no pin activity produces a byte.
- R3: Data-in is sampled on each rising serial clock edge, most significant bit first. After the eighth bit, `rx_valid_o` pulses for exactly one cycle with the byte on `rx_byte_o`.
- R4: The pause state cannot be entered while the block is deselected.
- R5: The pause starts when hold goes low while the serial clock is low, and ends when hold goes high while the clock is low. A hold change made while the clock is high takes effect only after the next falling clock edge.
- R6: While paused, `miso_oe_o` is low and clock and data-in edges are ignored. After resume, the transfer continues from the same bit position.
- R7: Raising chip select, including during a pause, clears the pause, the bit position and `rx_valid_o`, and drives `miso_oe_o` low. The next selection starts a fresh byte.
- R8: `miso_o` carries `tx_byte_i` most significant bit first. The byte is loaded at selection and reloaded at the falling edge that ends each byte. The pin shifts on falling clock edges and is enabled while selected and not paused.
- R9: `standby_o` is high when chip select is high and `busy_i` is low, and low otherwise. `selected_o` reports active mode.
- R10: Transfers work with the serial clock idling high (mode 3) as well as low (mode 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Supply-good level; low holds the block cleared |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause request, active low |
| busy_i | input | 1 | Write cycle in progress |
| tx_byte_i | input | BYTE_W | Next byte to shift out |
| rx_byte_o | output | BYTE_W | Last complete received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new received byte |
| selected_o | output | 1 | Block selected (active mode) |
| held_o | output | 1 | Transfer paused |
| standby_o | output | 1 | Idle bus, no write cycle running |
| miso_o | output | 1 | Serial data out value |
| miso_oe_o | output | 1 | Output enable for serial data out |

## Verification
The hardest state to reach is a pause request that arrives while the serial clock is high, on either entry or exit. Only correct ordering against the next falling clock edge separates a deferred pause from an immediate one. The stimulus stops mid-bit with the clock high, toggles hold, checks that the pause state has not yet changed, and only then drops the clock. Each bit is held for several system clocks so that the synchronizer delay cannot hide the difference. The bench then finishes the byte and checks the received value and the output bits to confirm that the position survived.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int unsigned PIN_W = 4;

  typedef struct packed {
    logic cs_n;
    logic sck;
    logic mosi;
    logic hold_n;
  } pins_t;

  // select must be seen high before it counts, so it clears to low
  localparam pins_t PINS_RST = '{cs_n: 1'b0, sck: 1'b0, mosi: 1'b0, hold_n: 1'b1};
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] nxt;
    if (g == 0) begin : g_first
      assign nxt = d_i;
    end else begin : g_rest
      assign nxt = stg_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stg_q[g] <= RST_VAL;
      else if (clr_i) stg_q[g] <= RST_VAL;
      else            stg_q[g] <= nxt;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic hold_n_i,
  output logic sel_o,
  output logic load_o,
  output logic held_o,
  output logic rise_o,
  output logic fall_o
);
  logic cs_prev_q, sck_prev_q, sel_q, held_q;
  logic cs_fall, gate;

  assign cs_fall = cs_prev_q & ~cs_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev_q  <= 1'b0;
      sck_prev_q <= 1'b0;
      sel_q      <= 1'b0;
      held_q     <= 1'b0;
    end else if (clr_i) begin
      cs_prev_q  <= 1'b0;
      sck_prev_q <= 1'b0;
      sel_q      <= 1'b0;
      held_q     <= 1'b0;
    end else begin
      cs_prev_q  <= cs_n_i;
      sck_prev_q <= sck_i;
      if (cs_n_i)       sel_q <= 1'b0;
      else if (cs_fall) sel_q <= 1'b1;
      // pause changes only while clock is low
      if (cs_n_i || !sel_q) held_q <= 1'b0;
      else if (!sck_i)      held_q <= ~hold_n_i;
    end
  end

  assign gate   = sel_q & ~held_q & ~cs_n_i;
  assign rise_o = gate & sck_i & ~sck_prev_q;
  assign fall_o = gate & ~sck_i & sck_prev_q;
  assign load_o = cs_fall;
  assign sel_o  = sel_q;
  assign held_o = held_q;
endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mosi_i,
  input  logic [BYTE_W-1:0] tx_i,
  output logic [BYTE_W-1:0] rx_o,
  output logic              valid_o,
  output logic              miso_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] rx_sh_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      rx_sh_q <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (load_i) begin
        tx_q  <= tx_i;
        cnt_q <= '0;
      end else if (clr_i) begin
        cnt_q <= '0;
      end else begin
        if (rise_i) begin
          rx_sh_q <= {rx_sh_q[BYTE_W-3:0], mosi_i};
          cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            rx_q    <= {rx_sh_q, mosi_i};
            valid_q <= 1'b1;
          end
        end
        if (fall_i) tx_q <= (cnt_q == '0) ? tx_i : {tx_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign rx_o    = rx_q;
  assign valid_o = valid_q;
  assign miso_o  = tx_q[BYTE_W-1];
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend #(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_i,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              hold_ni,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              selected_o,
  output logic              held_o,
  output logic              standby_o,
  output logic              miso_o,
  output logic              miso_oe_o
);
  import spi_fe_pkg::*;
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  pins_t            pins_raw, pins_s;
  logic             pwr_clr, sel, load, rise, fall;
  logic [CNT_W-1:0] bit_cnt;

  assign pwr_clr  = ~pwr_ok_i;
  assign pins_raw = '{cs_n: cs_ni, sck: sck_i, mosi: mosi_i, hold_n: hold_ni};

  spi_fe_sync #(
    .W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_RST)
  ) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(pwr_clr),
    .d_i(pins_raw), .q_o(pins_s)
  );

  spi_fe_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(pwr_clr),
    .cs_n_i(pins_s.cs_n), .sck_i(pins_s.sck), .hold_n_i(pins_s.hold_n),
    .sel_o(sel), .load_o(load), .held_o(held_o),
    .rise_o(rise), .fall_o(fall)
  );

  spi_fe_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(~sel),
    .load_i(load), .rise_i(rise), .fall_i(fall),
    .mosi_i(pins_s.mosi), .tx_i(tx_byte_i),
    .rx_o(rx_byte_o), .valid_o(rx_valid_o),
    .miso_o(miso_o), .cnt_o(bit_cnt)
  );

  assign selected_o = sel;
  assign miso_oe_o  = sel & ~held_o;
  assign standby_o  = pwr_ok_i & pins_s.cs_n & ~busy_i;
endmodule

// File: rtl/spi_hold_frontend_chk.sv
module spi_hold_frontend_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pwr_ok_i,
  input logic             cs_s_i,
  input logic             selected_i,
  input logic             held_i,
  input logic             rx_valid_i,
  input logic [CNT_W-1:0] bit_cnt_i
);
  AST_PWR_LOCKOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> !selected_i && !rx_valid_i); // R2
  AST_ARM_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(selected_i) |-> !$past(cs_s_i) && $past(cs_s_i, 2)); // R1
  AST_HOLD_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_i |-> selected_i); // R4
  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_i && $past(held_i) |-> $stable(bit_cnt_i)); // R6
  AST_DESEL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !selected_i |=> bit_cnt_i == '0 && !rx_valid_i); // R7
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> !rx_valid_i); // R3
endmodule

bind spi_hold_frontend spi_hold_frontend_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_ok_i(pwr_ok_i),
  .cs_s_i(pins_s.cs_n), .selected_i(selected_o), .held_i(held_o),
  .rx_valid_i(rx_valid_o), .bit_cnt_i(bit_cnt)
);

// File: tb/sim_spi_hold_frontend.sv
module sim_spi_hold_frontend;
  localparam int H = 8;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       pwr_ok = 1'b1, cs_n = 1'b0, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1, busy = 1'b0;
  logic [7:0] tx_byte = 8'h3C;
  logic [7:0] rx_byte;
  logic       rx_valid, selected, held, standby, miso, miso_oe;

  int checks = 0, fails = 0, rx_cnt = 0;
  logic [7:0] rx_last = '0;

  always #2.5 clk = ~clk;

  spi_hold_frontend u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr_ok), .cs_ni(cs_n), .sck_i(sck),
    .mosi_i(mosi), .hold_ni(hold_n), .busy_i(busy), .tx_byte_i(tx_byte),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .selected_o(selected),
    .held_o(held), .standby_o(standby), .miso_o(miso), .miso_oe_o(miso_oe)
  );

  always @(negedge clk) if (rx_valid) begin
    rx_cnt++;
    rx_last = rx_byte;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: act=running exp=done");
    summary();
  end

  task automatic chk(input logic ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (H) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_bit(input logic b, input logic exp_q, input string req);
    mosi = b; settle();
    chk(miso_oe === 1'b1, req, "miso_oe", miso_oe, 1);
    chk(miso === exp_q, req, "miso bit", miso, exp_q);
    sck = 1'b1; settle();
    sck = 1'b0; settle();
  endtask

  task automatic xfer(input logic [7:0] mo, input logic [7:0] exp_q, input string req);
    int base = rx_cnt;
    for (int i = 7; i >= 0; i--) do_bit(mo[i], exp_q[i], req);
    chk(rx_cnt == base + 1, req, "byte count", rx_cnt - base, 1);
    chk(rx_last == mo, req, "rx byte", rx_last, mo);
  endtask

  task automatic reselect();
    cs_n = 1'b1; settle();
    cs_n = 1'b0; settle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; settle(); rst_n = 1'b1; settle(); settle();
    chk(selected == 1'b0, "R1", "selected with cs low from power-up", selected, 0);
    chk(miso_oe == 1'b0, "R1", "miso_oe after reset", miso_oe, 0);
    chk(standby == 1'b0, "R9", "standby with cs low", standby, 0);
    chk(rx_cnt == 0, "R1", "no byte after reset", rx_cnt, 0);
  endtask

  task automatic t_arm();
    cs_n = 1'b1; settle();
    chk(selected == 1'b0, "R1", "selected while cs high", selected, 0);
    chk(standby == 1'b1, "R9", "standby cs high idle", standby, 1);
    cs_n = 1'b0; settle();
    chk(selected == 1'b1, "R1", "selected after fall", selected, 1);
    chk(standby == 1'b0, "R9", "standby when active", standby, 0);
  endtask

  task automatic t_mode0();
    tx_byte = 8'hC3;
    xfer(8'hA5, 8'h3C, "R3");
    xfer(8'h5A, 8'hC3, "R8");
    cs_n = 1'b1; settle();
    chk(miso_oe == 1'b0, "R7", "miso_oe after deselect", miso_oe, 0);
  endtask

  task automatic t_hold_basic();
    int base;
    logic [7:0] mo = 8'h96;
    tx_byte = 8'hF0;
    cs_n = 1'b0; settle();
    for (int i = 7; i >= 5; i--) do_bit(mo[i], tx_byte[i], "R6");
    base = rx_cnt;
    hold_n = 1'b0; settle();
    chk(held == 1'b1, "R5", "pause entry with clock low", held, 1);
    chk(miso_oe == 1'b0, "R6", "miso_oe during pause", miso_oe, 0);
    for (int k = 0; k < 6; k++) begin
      mosi = k[0]; sck = 1'b1; settle(); sck = 1'b0; settle();
    end
    chk(rx_cnt == base, "R6", "edges ignored in pause", rx_cnt - base, 0);
    hold_n = 1'b1; settle();
    chk(held == 1'b0, "R5", "pause exit with clock low", held, 0);
    for (int i = 4; i >= 0; i--) do_bit(mo[i], tx_byte[i], "R6");
    chk(rx_cnt == base + 1, "R6", "byte count across pause", rx_cnt - base, 1);
    chk(rx_last == mo, "R6", "position kept across pause", rx_last, mo);
  endtask

  task automatic t_hold_defer();
    int base;
    logic [7:0] mo = 8'h3B;
    tx_byte = 8'h0F;
    reselect();
    base = rx_cnt;
    for (int i = 7; i >= 4; i--) do_bit(mo[i], tx_byte[i], "R5");
    mosi = mo[3]; settle();
    chk(miso === tx_byte[3], "R5", "miso before deferred pause", miso, tx_byte[3]);
    sck = 1'b1; settle();
    hold_n = 1'b0; settle();
    chk(held == 1'b0, "R5", "entry deferred while clock high", held, 0);
    sck = 1'b0; settle();
    chk(held == 1'b1, "R5", "entry after clock fall", held, 1);
    sck = 1'b1; settle();
    hold_n = 1'b1; settle();
    chk(held == 1'b1, "R5", "exit deferred while clock high", held, 1);
    sck = 1'b0; settle();
    chk(held == 1'b0, "R5", "exit after clock fall", held, 0);
    for (int i = 2; i >= 0; i--) do_bit(mo[i], tx_byte[i], "R5");
    chk(rx_cnt == base + 1, "R5", "byte count deferred", rx_cnt - base, 1);
    chk(rx_last == mo, "R5", "rx byte deferred", rx_last, mo);
  endtask

  task automatic t_hold_unsel();
    cs_n = 1'b1; settle();
    hold_n = 1'b0; settle();
    chk(held == 1'b0, "R4", "pause while deselected", held, 0);
    hold_n = 1'b1; settle();
  endtask

  task automatic t_desel();
    int base;
    tx_byte = 8'h55;
    cs_n = 1'b0; settle();
    for (int i = 0; i < 3; i++) do_bit(1'b1, tx_byte[7-i], "R7");
    hold_n = 1'b0; settle();
    chk(held == 1'b1, "R7", "paused before deselect", held, 1);
    cs_n = 1'b1; settle();
    chk(held == 1'b0, "R7", "pause cleared by deselect", held, 0);
    chk(selected == 1'b0, "R7", "deselected", selected, 0);
    chk(miso_oe == 1'b0, "R7", "miso_oe off", miso_oe, 0);
    hold_n = 1'b1; settle();
    cs_n = 1'b0; settle();
    xfer(8'h42, 8'h55, "R7");
    base = rx_cnt;
    for (int i = 0; i < 4; i++) do_bit(1'b0, tx_byte[7-i], "R7");
    cs_n = 1'b1; settle();
    chk(rx_cnt == base, "R7", "partial byte dropped", rx_cnt - base, 0);
    cs_n = 1'b0; settle();
    xfer(8'h99, 8'h55, "R7");
  endtask

  task automatic t_power();
    int base = rx_cnt;
    pwr_ok = 1'b0; cs_n = 1'b1; settle();
    chk(selected == 1'b0, "R2", "selected while supply bad", selected, 0);
    chk(standby == 1'b0, "R2", "standby while supply bad", standby, 0);
    cs_n = 1'b0; settle();
    for (int k = 0; k < 8; k++) begin
      mosi = k[0]; sck = 1'b1; settle(); sck = 1'b0; settle();
    end
    chk(selected == 1'b0, "R2", "no select while supply bad", selected, 0);
    chk(miso_oe == 1'b0, "R2", "miso_oe while supply bad", miso_oe, 0);
    chk(rx_cnt == base, "R2", "no byte while supply bad", rx_cnt - base, 0);
    pwr_ok = 1'b1; settle(); settle();
    chk(selected == 1'b0, "R1", "no select after supply returns", selected, 0);
    reselect();
    chk(selected == 1'b1, "R1", "select after fresh fall", selected, 1);
  endtask

  task automatic t_standby();
    cs_n = 1'b1; busy = 1'b0; settle();
    chk(standby == 1'b1, "R9", "standby idle", standby, 1);
    busy = 1'b1; settle();
    chk(standby == 1'b0, "R9", "standby while busy", standby, 0);
    busy = 1'b0; cs_n = 1'b0; settle();
    chk(standby == 1'b0, "R9", "standby when selected", standby, 0);
    chk(selected == 1'b1, "R9", "active when selected", selected, 1);
  endtask

  task automatic t_mode3();
    cs_n = 1'b1; settle();
    sck = 1'b1; tx_byte = 8'hA6; settle();
    cs_n = 1'b0; settle();
    sck = 1'b0; settle();
    xfer(8'h71, 8'hA6, "R10");
    cs_n = 1'b1; settle();
  endtask

  initial begin
    t_reset();
    t_arm();
    t_mode0();
    t_hold_basic();
    t_hold_defer();
    t_hold_unsel();
    t_desel();
    t_power();
    t_standby();
    t_mode3();
    summary();
  end
endmodule